// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Break Reporting

This block receives asynchronous serial characters using a base-clock enable that pulses sixteen times per bit period. It passes the serial line through a two-stage synchronizer and waits for the line to go low. It then confirms the start bit at the middle of its cell. After that it samples every later bit at the centre of its cell and assembles the character, least significant bit first. The frame format is set by four static inputs: seven or eight data bits, parity off, even or odd, and one or two stop bits.

A finished character is placed in a holding register. The block then emits a one-cycle strobe and raises a ready level, which stays high until the consumer acknowledges it. Overrun, parity and framing errors are sticky, and each has its own clear input. A framing-error frame whose data bits are all zero raises a break indication. That indication holds until the line returns high. The synchronized line level is also visible, so that software can confirm the break. While the line stays low, the receiver keeps framing characters, so the framing error reappears after it is cleared. Dropping the enable stops reception but leaves every flag as it was.

Top module: `osr_rx_top`

## Requirements
- R1: Bit timing counts the base-clock enable `tick_en`. The start bit is confirmed on the eighth tick after the synchronized low is first seen. Each later bit is sampled every sixteen ticks. While `tick_en` is low, the receiver makes no progress and receives no character.
- R2: If the synchronized line is high at the start-bit midpoint, the receiver returns to idle. No character, strobe or flag results.
- R3: With `cfg_eight` = 1, eight data bits are received. With `cfg_eight` = 0, seven data bits are received and `rx_data[7]` reads 0. Bits arrive LSB first.
- R4: With `cfg_par_en` = 1, a parity bit follows the data bits. The sender sets it so that the count of ones in data plus parity is even (`cfg_par_odd` = 0) or odd (`cfg_par_odd` = 1). A mismatch sets `err_par`. With parity off, `err_par` is never set.
- R5: `cfg_two_stop` selects one or two stop bits. If any stop bit is sampled low, `err_frm` is set.
- R6: When a frame completes, the block pulses `rx_strobe` for one cycle and sets `rx_rdy`. A pulse on `rx_ack` clears `rx_rdy`. If a frame completes while `rx_rdy` is set and not acknowledged in that cycle, `err_ovr` is set and `rx_data` keeps the older character.
- R7: `err_ovr`, `err_par` and `err_frm` stay set until their clear inputs `clr_ovr`, `clr_par` and `clr_frm` are pulsed. If a clear and a new error arrive in the same cycle, the flag ends up set.
- R8: If the line is held low, `err_frm` is set on every frame period, including after a clear. `brk_det` is set when a frame completes with a framing error and all-zero data, and it clears once the synchronized line reads high.
- R9: `line_level` reports the serial input after two register stages. It reads 1 out of reset.
- R10: While `rx_en` is 0, the receiver stays idle and receives nothing. `err_ovr`, `err_par`, `err_frm`, `rx_data` and `rx_rdy` keep their values.
- R11: After reset, `rx_rdy`, `rx_strobe`, all error flags and `brk_det` read 0, and `rx_data` reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Base-clock enable, 16 per bit period |
| rx_in | input | 1 | Asynchronous serial input, idle high |
| rx_en | input | 1 | Receive enable |
| cfg_eight | input | 1 | 1: eight data bits, 0: seven |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| rx_ack | input | 1 | Acknowledge received character |
| clr_ovr | input | 1 | Clear overrun flag |
| clr_par | input | 1 | Clear parity flag |
| clr_frm | input | 1 | Clear framing flag |
| rx_data | output | 8 | Received character |
| rx_strobe | output | 1 | One-cycle frame-complete pulse |
| rx_rdy | output | 1 | Character waiting for acknowledge |
| err_ovr | output | 1 | Sticky overrun flag |
| err_par | output | 1 | Sticky parity error flag |
| err_frm | output | 1 | Sticky framing error flag |
| brk_det | output | 1 | Break indication |
| line_level | output | 1 | Synchronized serial line level |

## Verification
The collision that matters is a software clear of the framing flag landing in the same cycle that a break frame sets that flag again. To provoke it, the bench holds the line low and holds `clr_frm` high until `rx_strobe` is seen. It releases the clear only after the edge that completed the frame. It then requires `err_frm` to read 1, because the set must have won. The other paths are covered around that case: a clear pulsed between break frames must be undone by the next frame, and overrun must keep the first character.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;

    localparam int OSR    = 16;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic eight;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } rx_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par_bad;
        logic              stop_bad;
    } rx_frame_t;

    // Parity bit the sender must have placed, given the XOR of the data bits.
    function automatic logic want_par(input logic acc, input logic odd);
        return acc ^ odd;
    endfunction

endpackage

// File: rtl/osr_rx_sync.sv
module osr_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], din};
    end

    assign dout = sh[STAGES-1];
endmodule

// File: rtl/osr_rx_fsm.sv
module osr_rx_fsm
    import osr_rx_pkg::*;
#(
    parameter int N_OSR = OSR
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      en,
    input  logic      line,
    input  rx_cfg_t   cfg,
    output logic      done,
    output rx_frame_t frame
);
    localparam int CW = $clog2(N_OSR);
    localparam logic [CW-1:0] MID_T  = CW'(N_OSR/2 - 1);
    localparam logic [CW-1:0] LAST_T = CW'(N_OSR - 1);

    rx_state_e         st;
    logic [CW-1:0]     cnt;
    logic [2:0]        bidx;
    logic              stop_idx;
    logic              acc;
    logic [DATA_W-1:0] shreg;
    logic              par_bad, stop_bad;
    logic [2:0]        last_bit;

    assign last_bit = cfg.eight ? 3'd7 : 3'd6;

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst || !en) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            bidx     <= '0;
            stop_idx <= 1'b0;
            acc      <= 1'b0;
            shreg    <= '0;
            par_bad  <= 1'b0;
            stop_bad <= 1'b0;
        end else if (tick) begin
            unique case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (!line) st <= ST_START;
                end
                ST_START: begin
                    if (cnt == MID_T) begin
                        cnt <= '0;
                        if (line) begin
                            st <= ST_IDLE;
                        end else begin
                            st       <= ST_DATA;
                            bidx     <= '0;
                            stop_idx <= 1'b0;
                            acc      <= 1'b0;
                            shreg    <= '0;
                            par_bad  <= 1'b0;
                            stop_bad <= 1'b0;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cnt == LAST_T) begin
                        cnt         <= '0;
                        shreg[bidx] <= line;
                        acc         <= acc ^ line;
                        if (bidx == last_bit) st <= cfg.par_en ? ST_PAR : ST_STOP;
                        else                  bidx <= bidx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (cnt == LAST_T) begin
                        cnt     <= '0;
                        par_bad <= (line != want_par(acc, cfg.par_odd));
                        st      <= ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (cnt == LAST_T) begin
                        cnt      <= '0;
                        stop_bad <= stop_bad | ~line;
                        if (stop_idx == cfg.two_stop) begin
                            done <= 1'b1;
                            st   <= ST_IDLE;
                        end else begin
                            stop_idx <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign frame.data     = shreg;
    assign frame.par_bad  = par_bad;
    assign frame.stop_bad = stop_bad;

    // R2: a high line at the start midpoint sends the receiver back to idle
    a_r2_false_start: assert property (@(posedge clk) disable iff (rst)
        (st == ST_START && tick && en && cnt == MID_T && line) |=> st == ST_IDLE);

    // R6: the frame-complete pulse lasts one cycle
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/osr_rx_flags.sv
module osr_rx_flags
    import osr_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_frame_t         frame,
    input  logic              line_level,
    input  logic              ack,
    input  logic              clr_ovr,
    input  logic              clr_par,
    input  logic              clr_frm,
    output logic [DATA_W-1:0] data_q,
    output logic              rdy,
    output logic              ovr,
    output logic              par,
    output logic              frm,
    output logic              brk
);
    logic is_break;
    assign is_break = frame.stop_bad && (frame.data == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            rdy    <= 1'b0;
            ovr    <= 1'b0;
            par    <= 1'b0;
            frm    <= 1'b0;
            brk    <= 1'b0;
        end else begin
            if (done && (!rdy || ack)) data_q <= frame.data;

            if (done)     rdy <= 1'b1;
            else if (ack) rdy <= 1'b0;

            if (done && rdy && !ack) ovr <= 1'b1;
            else if (clr_ovr)        ovr <= 1'b0;

            if (done && frame.par_bad) par <= 1'b1;
            else if (clr_par)          par <= 1'b0;

            if (done && frame.stop_bad) frm <= 1'b1;
            else if (clr_frm)           frm <= 1'b0;

            if (done && is_break) brk <= 1'b1;
            else if (line_level)  brk <= 1'b0;
        end
    end

    // R6: an overrun keeps the older character
    a_r6_keep_old: assert property (@(posedge clk) disable iff (rst)
        (done && rdy && !ack) |=> $stable(data_q));

    // R7: a new framing error beats a clear in the same cycle
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        (done && frame.stop_bad && clr_frm) |=> frm);

    // R8: a break is only reported alongside a framing error
    a_r8_brk_with_frm: assert property (@(posedge clk) disable iff (rst)
        $rose(brk) |-> frm);
endmodule

// File: rtl/osr_rx_top.sv
module osr_rx_top
    import osr_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       rx_in,
    input  logic       rx_en,
    input  logic       cfg_eight,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_two_stop,
    input  logic       rx_ack,
    input  logic       clr_ovr,
    input  logic       clr_par,
    input  logic       clr_frm,
    output logic [7:0] rx_data,
    output logic       rx_strobe,
    output logic       rx_rdy,
    output logic       err_ovr,
    output logic       err_par,
    output logic       err_frm,
    output logic       brk_det,
    output logic       line_level
);
    rx_cfg_t   cfg;
    rx_frame_t frame;
    logic      done;

    assign cfg = '{eight: cfg_eight, par_en: cfg_par_en,
                   par_odd: cfg_par_odd, two_stop: cfg_two_stop};

    osr_rx_sync #(.STAGES(2)) u_sync (
        .clk (clk), .rst (rst), .din (rx_in), .dout (line_level)
    );

    osr_rx_fsm #(.N_OSR(OSR)) u_fsm (
        .clk (clk), .rst (rst), .tick (tick_en), .en (rx_en),
        .line (line_level), .cfg (cfg), .done (done), .frame (frame)
    );

    osr_rx_flags u_flags (
        .clk (clk), .rst (rst), .done (done), .frame (frame),
        .line_level (line_level), .ack (rx_ack),
        .clr_ovr (clr_ovr), .clr_par (clr_par), .clr_frm (clr_frm),
        .data_q (rx_data), .rdy (rx_rdy), .ovr (err_ovr),
        .par (err_par), .frm (err_frm), .brk (brk_det)
    );

    assign rx_strobe = done;

    // R10: with reception disabled, a framing flag persists until cleared
    a_r10_hold_flags: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && err_frm && !clr_frm) |=> err_frm);

    // R10: with reception disabled, no character completes
    a_r10_no_strobe: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !$past(rx_en)) |-> !rx_strobe);
endmodule

// File: tb/sim_osr_rx_top.sv
module sim_osr_rx_top;
    localparam time TCLK = 10ns;

    logic       clk = 1'b0;
    logic       rst, tick_en, rx_in, rx_en;
    logic       cfg_eight, cfg_par_en, cfg_par_odd, cfg_two_stop;
    logic       rx_ack, clr_ovr, clr_par, clr_frm;
    logic [7:0] rx_data;
    logic       rx_strobe, rx_rdy, err_ovr, err_par, err_frm, brk_det, line_level;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    always #(TCLK/2) clk = ~clk;

    osr_rx_top u0 (.*);

    // vector: data[13:6], eight, par_en, par_odd, two_stop, bad_par, bad_stop
    localparam int NV = 8;
    localparam logic [13:0] VEC [NV] = '{
        {8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h81, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h55, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'h0F, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic hold(input logic v);
        rx_in = v;
        repeat (16) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
        logic acc = 1'b0;
        int   nb  = cfg_eight ? 8 : 7;
        hold(1'b0);
        for (int i = 0; i < nb; i++) begin
            hold(d[i]);
            acc ^= d[i];
        end
        if (cfg_par_en) hold((acc ^ cfg_par_odd) ^ bad_par);
        if (cfg_two_stop) hold(1'b1);
        hold(~bad_stop);
        rx_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_clears();
        rx_ack = 1; clr_ovr = 1; clr_par = 1; clr_frm = 1;
        @(negedge clk);
        rx_ack = 0; clr_ovr = 0; clr_par = 0; clr_frm = 0;
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic e, input logic pe, input logic po, input logic ts);
        cfg_eight = e; cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = ts;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        rst = 1; tick_en = 1; rx_in = 1; rx_en = 1;
        rx_ack = 0; clr_ovr = 0; clr_par = 0; clr_frm = 0;
        set_cfg(1, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R11 / R9 reset state
        check("R11 rdy", rx_rdy, 0);
        check("R11 flags", {err_ovr, err_par, err_frm, brk_det, rx_strobe}, 0);
        check("R11 data", rx_data, 8'h00);
        check("R9 line idle", line_level, 1);

        // R3 R4 R5 R6 vector table
        for (int v = 0; v < NV; v++) begin
            logic [7:0] d = VEC[v][13:6];
            set_cfg(VEC[v][5], VEC[v][4], VEC[v][3], VEC[v][2]);
            send(d, VEC[v][1], VEC[v][0]);
            check("R6 rdy set", rx_rdy, 1);
            check("R3 data", rx_data, VEC[v][5] ? d : {1'b0, d[6:0]});
            check("R4 parity flag", err_par, VEC[v][4] & VEC[v][1]);
            check("R5 framing flag", err_frm, VEC[v][0]);
            pulse_clears();
            check("R6 ack clears rdy", rx_rdy, 0);
            check("R7 clears", {err_par, err_frm}, 0);
        end

        // R2 false start
        set_cfg(1, 0, 0, 0);
        rx_in = 0;
        repeat (5) @(negedge clk);
        rx_in = 1;
        repeat (200) @(negedge clk);
        check("R2 no char", rx_rdy, 0);
        check("R2 no flag", err_frm, 0);

        // R1 ticks frozen: a whole frame with tick_en low yields nothing
        tick_en = 0;
        send(8'h5A, 0, 0);
        check("R1 frozen no char", rx_rdy, 0);
        tick_en = 1;
        send(8'h5A, 0, 0);
        check("R1 resumed char", rx_data, 8'h5A);
        pulse_clears();

        // R6 overrun keeps old data
        send(8'h11, 0, 0);
        send(8'h22, 0, 0);
        check("R6 overrun flag", err_ovr, 1);
        check("R6 old data kept", rx_data, 8'h11);
        pulse_clears();

        // R10 rx_en low: flags held, nothing received
        send(8'h33, 0, 1);
        rx_ack = 1; @(negedge clk); rx_ack = 0;
        rx_en = 0;
        repeat (5) @(negedge clk);
        check("R10 frm held", err_frm, 1);
        send(8'h44, 0, 0);
        check("R10 no char", rx_rdy, 0);
        check("R10 data held", rx_data, 8'h33);
        rx_en = 1;
        pulse_clears();

        // R8 break: line held low
        rx_in = 0;
        repeat (200) @(negedge clk);
        check("R8 frm on break", err_frm, 1);
        check("R8 brk_det", brk_det, 1);
        check("R9 line low", line_level, 0);
        check("R8 break data", rx_data, 8'h00);
        clr_frm = 1; @(negedge clk); clr_frm = 0;
        check("R7 cleared", err_frm, 0);
        repeat (160) @(negedge clk);
        check("R8 frm reasserts", err_frm, 1);

        // R7 clear collides with a new framing error
        clr_frm = 1;
        for (int k = 0; k < 400 && !rx_strobe; k++) @(negedge clk);
        check("R7 strobe seen", rx_strobe, 1);
        @(negedge clk);
        clr_frm = 0;
        check("R7 set wins", err_frm, 1);

        // R8 release of break
        rx_in = 1;
        repeat (10) @(negedge clk);
        check("R8 brk clears", brk_det, 0);
        check("R9 line high", line_level, 1);

        finish_run();
    end
endmodule